// File: doc/BRIEF.md
# SDRAM Burst Interrupt Command Sequencer

This block sits on the controller side of a single-data-rate SDRAM. It turns host column requests into READ, WRITE, PRECHARGE and NOP commands. Each request carries a direction, a bank and a column, and may also carry a write word, a close-the-row flag and a wanted read length. The block keeps column commands back to back. A later READ or WRITE ends the burst in progress, and a PRECHARGE placed on an exact cycle cuts a read burst to the wanted length. When a burst runs to its full length and the row is to be closed, the block can instead set the auto-precharge address bit on the column command.

Write data leaves on the DQ output in the same cycle as its WRITE command. When no further command follows a write, the burst words the host did not supply are masked with DQM. Read words are captured a CAS latency after their READ and handed back to the host one per cycle. The block holds a WRITE back until the read words already on their way have cleared the bus, so that DQ never has two drivers.

Top module: `sdramBurstSeq`

## Requirements
- R1: While reset is held, and in the first cycle after it, the command is NOP, sdDqOe, sdDqm and rdValid are low, and reqReady is high.
- R2: The command is encoded on sdCmd as {RAS#, CAS#, WE#}: NOP 3'b111, READ 3'b101, WRITE 3'b100, PRECHARGE 3'b010. A request accepted at a clock edge appears on sdCmd/sdBank/sdAddr (column in the low bits) in the cycle that follows that edge. Every cycle without a command carries NOP.
- R3: A WRITE drives its request word on sdDqOut with sdDqOe high in the WRITE cycle itself, and writes can be accepted on consecutive edges, each with its own word and with sdDqm low.
- R4: For a READ on sdCmd in cycle c, the word present on sdDqIn at the CL-th edge after that cycle is returned on rdData with rdValid high in cycle c+CL+1. BL words follow on consecutive cycles.
- R5: A READ issued while an earlier read burst is still running ends that burst. The old words stop and the new burst's words follow on without a gap.
- R6: A READ requested right after a WRITE is accepted on the next edge, which ends the write burst. sdDqm is low and sdDqOe is low in the READ cycle.
- R7: A WRITE is issued no earlier than the cycle after the one in which the last pending read word is returned on rdValid, so sdDqOe is never high while the SDRAM drives DQ.
- R8: After a WRITE that no command follows, sdDqm is high on the next BL-1 NOP cycles and low again afterwards.
- R9: A READ with reqPre set and reqLen L below BL (or any such READ when AUTO_PRE is 0) is followed L cycles later by a PRECHARGE to the same bank with sdAddr[10] low. Exactly L words are returned, and reqReady is low until the cycle after the PRECHARGE. A reqLen of 0 or above BL counts as BL.
- R10: With AUTO_PRE set, a full-length READ with reqPre carries sdAddr[10] high, and no command other than NOP is issued for the following BL-1 cycles.
- R11: A WRITE with reqPre (BL above 1) is followed 1+WR_GAP cycles later by a PRECHARGE to its bank, and the leftover burst words in between are masked with sdDqm.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Host request present |
| reqReady | output | 1 | Request is accepted at the coming edge |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqBank | input | BANK_W | Target bank |
| reqCol | input | COL_W | Start column |
| reqWdata | input | DATA_W | Write word |
| reqPre | input | 1 | Close the row after this burst |
| reqLen | input | $clog2(BL)+1 | Wanted read words when closing |
| sdCmd | output | 3 | {RAS#, CAS#, WE#} |
| sdBank | output | BANK_W | Bank address |
| sdAddr | output | ADDR_W | Column and auto-precharge bit |
| sdDqm | output | 1 | Data mask |
| sdDqOe | output | 1 | DQ output enable |
| sdDqOut | output | DATA_W | DQ write data |
| sdDqIn | input | DATA_W | DQ read data |
| rdValid | output | 1 | Returned read word valid |
| rdData | output | DATA_W | Returned read word |

## Verification
The assertions assume that the host holds a request stable until it is accepted, and that the SDRAM returns each read word exactly CL edges after the matching READ or burst position. The bench's SDRAM model follows that timing, and the bench drives every request at the falling edge and keeps it until reqReady has been seen high. The assertions also rely on reqLen being either in range or treated as BL. The bench uses only lengths of 0, 2 and BL.

// File: rtl/sbsPkg.sv
package sbsPkg;

  // {RAS#, CAS#, WE#}
  typedef enum logic [2:0] {
    CMD_NOP   = 3'b111,
    CMD_READ  = 3'b101,
    CMD_WRITE = 3'b100,
    CMD_PRE   = 3'b010
  } sbsCmd_e;

  typedef struct packed {
    logic issueRd;
    logic issueWr;
    logic issuePre;
    logic setA10;
  } sbsStrobe_t;

endpackage

// File: rtl/sbsCtrl.sv
module sbsCtrl
  import sbsPkg::*;
#(
  parameter int BL       = 4,
  parameter int BANK_W   = 2,
  parameter int WR_GAP   = 1,
  parameter bit AUTO_PRE = 1'b1,
  parameter int LEN_W    = $clog2(BL) + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [BANK_W-1:0] reqBank,
  input  logic              reqPre,
  input  logic [LEN_W-1:0]  reqLen,
  input  logic              readBusy,
  output logic              reqReady,
  output sbsStrobe_t        stb,
  output logic [BANK_W-1:0] preBank
);

  localparam int CNT_W = $clog2(BL + WR_GAP + 2) + 1;

  logic [CNT_W-1:0] holdCnt;
  logic             preArmed;
  logic [LEN_W-1:0] effLen;
  logic [CNT_W-1:0] closeDly;
  logic             fullLen, useAuto, accept;

  always_comb begin
    effLen   = (reqLen == '0 || reqLen > LEN_W'(BL)) ? LEN_W'(BL) : reqLen;
    fullLen  = reqWrite ? (BL == 1) : (effLen == LEN_W'(BL));
    useAuto  = reqPre && AUTO_PRE && fullLen;
    closeDly = reqWrite ? CNT_W'(1 + WR_GAP) : CNT_W'(effLen);
    reqReady = (holdCnt == '0) && !(reqWrite && readBusy);
    accept   = reqValid && reqReady;
    stb.issueRd  = accept && !reqWrite;
    stb.issueWr  = accept && reqWrite;
    stb.issuePre = (holdCnt == CNT_W'(1)) && preArmed;
    stb.setA10   = accept && useAuto;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdCnt  <= '0;
      preArmed <= 1'b0;
      preBank  <= '0;
    end else if (accept && reqPre) begin
      holdCnt  <= useAuto ? closeDly - CNT_W'(1) : closeDly;
      preArmed <= !useAuto;
      preBank  <= reqBank;
    end else if (holdCnt != '0) begin
      holdCnt <= holdCnt - CNT_W'(1);
      if (holdCnt == CNT_W'(1)) preArmed <= 1'b0;
    end
  end

  AST_ONE_CMD: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.issueRd, stb.issueWr, stb.issuePre})); // R2

  AST_AUTO_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    ((BL > 1) && stb.setA10 && stb.issueRd) |=> !(stb.issueRd || stb.issueWr)); // R10

endmodule

// File: rtl/sbsData.sv
module sbsData
  import sbsPkg::*;
#(
  parameter int DATA_W = 16,
  parameter int COL_W  = 10,
  parameter int ADDR_W = 13,
  parameter int BANK_W = 2,
  parameter int BL     = 4,
  parameter int CL     = 2,
  parameter int AP_BIT = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  sbsStrobe_t        stb,
  input  logic [BANK_W-1:0] reqBank,
  input  logic [COL_W-1:0]  reqCol,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [BANK_W-1:0] preBank,
  input  logic [DATA_W-1:0] sdDqIn,
  output logic [2:0]        sdCmd,
  output logic [BANK_W-1:0] sdBank,
  output logic [ADDR_W-1:0] sdAddr,
  output logic              sdDqm,
  output logic              sdDqOe,
  output logic [DATA_W-1:0] sdDqOut,
  output logic              rdValid,
  output logic [DATA_W-1:0] rdData,
  output logic              readBusy
);

  localparam int LEFT_W = $clog2(BL) + 1;

  sbsCmd_e           cmdQ;
  logic              beatNow;
  logic [LEFT_W-1:0] rdLeft, wrLeft;
  logic [CL-1:0]     rdShift;
  logic [ADDR_W-1:0] colAddr;

  always_comb begin
    colAddr                = '0;
    colAddr[COL_W-1:0]     = reqCol;
    colAddr[AP_BIT]        = stb.setA10;
  end

  assign sdCmd    = cmdQ;
  assign readBusy = beatNow || (rdLeft != '0) || (rdShift != '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdQ    <= CMD_NOP;
      sdBank  <= '0;
      sdAddr  <= '0;
      sdDqm   <= 1'b0;
      sdDqOe  <= 1'b0;
      sdDqOut <= '0;
      beatNow <= 1'b0;
      rdLeft  <= '0;
      wrLeft  <= '0;
    end else begin
      sdDqOe <= 1'b0;
      sdDqm  <= 1'b0;
      if (stb.issuePre) begin
        cmdQ    <= CMD_PRE;
        sdBank  <= preBank;
        sdAddr  <= '0;
        beatNow <= 1'b0;
        rdLeft  <= '0;
        wrLeft  <= '0;
      end else if (stb.issueRd) begin
        cmdQ    <= CMD_READ;
        sdBank  <= reqBank;
        sdAddr  <= colAddr;
        beatNow <= 1'b1;
        rdLeft  <= LEFT_W'(BL - 1);
        wrLeft  <= '0;
      end else if (stb.issueWr) begin
        cmdQ    <= CMD_WRITE;
        sdBank  <= reqBank;
        sdAddr  <= colAddr;
        sdDqOe  <= 1'b1;
        sdDqOut <= reqWdata;
        beatNow <= 1'b0;
        rdLeft  <= '0;
        wrLeft  <= LEFT_W'(BL - 1);
      end else begin
        cmdQ    <= CMD_NOP;
        sdDqm   <= (wrLeft != '0);
        beatNow <= (rdLeft != '0);
        if (wrLeft != '0) wrLeft <= wrLeft - LEFT_W'(1);
        if (rdLeft != '0) rdLeft <= rdLeft - LEFT_W'(1);
      end
    end
  end

  // read beats travel CL stages to meet their data on the bus
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdShift <= '0;
      rdValid <= 1'b0;
      rdData  <= '0;
    end else begin
      rdShift[0] <= beatNow;
      for (int i = 1; i < CL; i++) rdShift[i] <= rdShift[i-1];
      rdValid <= rdShift[CL-1];
      if (rdShift[CL-1]) rdData <= sdDqIn;
    end
  end

  AST_BUS_TURN: assert property (@(posedge clk) disable iff (!rstN)
    sdDqOe |-> (rdShift == '0 && !rdValid)); // R7

  AST_DQM_ON_NOP: assert property (@(posedge clk) disable iff (!rstN)
    sdDqm |-> (sdCmd == CMD_NOP)); // R8

endmodule

// File: rtl/sdramBurstSeq.sv
module sdramBurstSeq
  import sbsPkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int COL_W    = 10,
  parameter int ADDR_W   = 13,
  parameter int BANK_W   = 2,
  parameter int BL       = 4,
  parameter int CL       = 2,
  parameter int WR_GAP   = 1,
  parameter bit AUTO_PRE = 1'b1,
  parameter int AP_BIT   = 10,
  parameter int LEN_W    = $clog2(BL) + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqWrite,
  input  logic [BANK_W-1:0] reqBank,
  input  logic [COL_W-1:0]  reqCol,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic              reqPre,
  input  logic [LEN_W-1:0]  reqLen,
  output logic [2:0]        sdCmd,
  output logic [BANK_W-1:0] sdBank,
  output logic [ADDR_W-1:0] sdAddr,
  output logic              sdDqm,
  output logic              sdDqOe,
  output logic [DATA_W-1:0] sdDqOut,
  input  logic [DATA_W-1:0] sdDqIn,
  output logic              rdValid,
  output logic [DATA_W-1:0] rdData
);

  sbsStrobe_t        stb;
  logic [BANK_W-1:0] preBank;
  logic              readBusy;

  sbsCtrl #(.BL(BL), .BANK_W(BANK_W), .WR_GAP(WR_GAP), .AUTO_PRE(AUTO_PRE),
            .LEN_W(LEN_W)) ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqBank(reqBank), .reqPre(reqPre), .reqLen(reqLen), .readBusy(readBusy),
    .reqReady(reqReady), .stb(stb), .preBank(preBank)
  );

  sbsData #(.DATA_W(DATA_W), .COL_W(COL_W), .ADDR_W(ADDR_W), .BANK_W(BANK_W),
            .BL(BL), .CL(CL), .AP_BIT(AP_BIT)) data (
    .clk(clk), .rstN(rstN), .stb(stb), .reqBank(reqBank), .reqCol(reqCol),
    .reqWdata(reqWdata), .preBank(preBank), .sdDqIn(sdDqIn), .sdCmd(sdCmd),
    .sdBank(sdBank), .sdAddr(sdAddr), .sdDqm(sdDqm), .sdDqOe(sdDqOe),
    .sdDqOut(sdDqOut), .rdValid(rdValid), .rdData(rdData), .readBusy(readBusy)
  );

endmodule

// File: tb/sdramBurstSeq_test.sv
module sdramBurstSeq_test;
  localparam int BL = 4, CL = 2, LOG_N = 1024;
  localparam logic [2:0] NOP = 3'b111, RD = 3'b101, WR = 3'b100, PR = 3'b010;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rstN, reqValid, reqReady, reqWrite, reqPre;
  logic [1:0] reqBank;
  logic [9:0] reqCol;
  logic [15:0] reqWdata, sdDqOut, sdDqIn, rdData;
  logic [2:0] reqLen, sdCmd;
  logic [1:0] sdBank;
  logic [12:0] sdAddr;
  logic sdDqm, sdDqOe, rdValid;

  sdramBurstSeq #(.BL(BL), .CL(CL), .WR_GAP(1), .AUTO_PRE(1'b1)) uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqBank(reqBank), .reqCol(reqCol), .reqWdata(reqWdata),
    .reqPre(reqPre), .reqLen(reqLen), .sdCmd(sdCmd), .sdBank(sdBank),
    .sdAddr(sdAddr), .sdDqm(sdDqm), .sdDqOe(sdDqOe), .sdDqOut(sdDqOut),
    .sdDqIn(sdDqIn), .rdValid(rdValid), .rdData(rdData)
  );

  int nChk = 0, nFail = 0, cyc = 0;
  bit done = 1'b0;

  task automatic chk(input string tag, input int act, input int exp);
    nChk++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] wordOf(input logic [1:0] b, input logic [9:0] c, input int idx);
    logic [9:0] cb;
    cb = (c & ~10'(BL - 1)) | (10'(c + 10'(idx)) & 10'(BL - 1));
    return {2'b10, b, 2'b00, cb};
  endfunction

  // behavioural SDRAM: read data stable at the CL-th edge after the command edge
  logic mdAct, s1V, mdDrive, oV;
  logic [1:0] mdBank;
  logic [9:0] mdCol;
  int mdIdx;
  logic [15:0] s1W, oW;
  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mdAct <= 1'b0; s1V <= 1'b0; mdDrive <= 1'b0; sdDqIn <= '0;
    end else begin
      oV = 1'b0; oW = '0;
      if (sdCmd == RD) begin
        oV = 1'b1; oW = wordOf(sdBank, sdAddr[9:0], 0);
        mdBank <= sdBank; mdCol <= sdAddr[9:0]; mdIdx <= 1; mdAct <= (BL > 1);
      end else if (sdCmd == WR || sdCmd == PR) begin
        mdAct <= 1'b0;
      end else if (mdAct) begin
        oV = 1'b1; oW = wordOf(mdBank, mdCol, mdIdx);
        mdIdx <= mdIdx + 1;
        if (mdIdx == BL - 1) mdAct <= 1'b0;
      end
      s1V <= oV; s1W <= oW;
      mdDrive <= s1V;
      sdDqIn <= s1V ? s1W : 16'h0;
    end
  end

  always @(posedge clk) cyc <= cyc + 1;

  logic [2:0] cmdLog [LOG_N];
  logic [12:0] addrLog [LOG_N];
  logic [1:0] bankLog [LOG_N];
  logic dqmLog [LOG_N], oeLog [LOG_N], rvLog [LOG_N];
  logic [15:0] doutLog [LOG_N], rdLog [LOG_N];

  always @(negedge clk) begin
    if (cyc < LOG_N) begin
      cmdLog[cyc] = sdCmd; addrLog[cyc] = sdAddr; bankLog[cyc] = sdBank;
      dqmLog[cyc] = sdDqm; oeLog[cyc] = sdDqOe; doutLog[cyc] = sdDqOut;
      rvLog[cyc] = rdValid; rdLog[cyc] = rdData;
    end
    if (rstN && sdDqOe) chk("R7 bus clash", int'(mdDrive), 0);
  end

  task automatic req(input bit wr, input logic [1:0] b, input logic [9:0] c,
                     input logic [15:0] d, input bit pre, input logic [2:0] len,
                     output int acc);
    @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqBank = b; reqCol = c;
    reqWdata = d; reqPre = pre; reqLen = len;
    #1;
    while (!reqReady) begin
      @(negedge clk);
      #1;
    end
    acc = cyc + 1;
    @(posedge clk);
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    reqValid = 1'b0; reqPre = 1'b0;
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  // {bank, column, first expected word}
  localparam logic [27:0] TBL [4] = '{
    {2'd1, 10'h005, 16'h9005},
    {2'd2, 10'h3FE, 16'hA3FE},
    {2'd3, 10'h010, 16'hB010},
    {2'd0, 10'h001, 16'h8001}
  };

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      nFail++; nChk++;
      $display("FAIL watchdog: actual running expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
      $finish;
    end
  end

  initial begin
    int a, a2, a3, b;
    rstN = 1'b0; reqValid = 1'b0; reqWrite = 1'b0; reqBank = '0; reqCol = '0;
    reqWdata = '0; reqPre = 1'b0; reqLen = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 cmd in reset", int'(sdCmd), int'(NOP));
    chk("R1 oe/dqm/rdValid in reset", int'({sdDqOe, sdDqm, rdValid}), 0);
    chk("R1 ready in reset", int'(reqReady), 1);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 cmd after reset", int'(sdCmd), int'(NOP));

    // R4 / R2: table of single reads
    for (int t = 0; t < 4; t++) begin
      req(1'b0, TBL[t][27:26], TBL[t][25:16], 16'h0, 1'b0, 3'd0, a);
      idle(10);
      chk("R2 read cmd", int'(cmdLog[a]), int'(RD));
      chk("R2 read bank", int'(bankLog[a]), int'(TBL[t][27:26]));
      chk("R2 read column", int'(addrLog[a][10:0]), int'(TBL[t][25:16]));
      chk("R2 nop after", int'(cmdLog[a+1]), int'(NOP));
      chk("R4 first word", int'(rdLog[a+3]), int'(TBL[t][15:0]));
      for (int i = 0; i < BL; i++) begin
        chk("R4 valid", int'(rvLog[a+CL+1+i]), 1);
        chk("R4 word", int'(rdLog[a+CL+1+i]), int'(wordOf(TBL[t][27:26], TBL[t][25:16], i)));
      end
      chk("R4 burst end", int'(rvLog[a+CL+1+BL]), 0);
    end

    // R3 / R8: back-to-back writes then masked leftovers
    req(1'b1, 2'd1, 10'h040, 16'h1111, 1'b0, 3'd0, a);
    req(1'b1, 2'd2, 10'h081, 16'h2222, 1'b0, 3'd0, a2);
    req(1'b1, 2'd3, 10'h0C2, 16'h3333, 1'b0, 3'd0, a3);
    idle(8);
    chk("R3 consecutive", a2 - a, 1);
    chk("R3 consecutive", a3 - a2, 1);
    chk("R3 write cmd", int'(cmdLog[a2]), int'(WR));
    chk("R3 data same cycle", int'(doutLog[a]), 16'h1111);
    chk("R3 data same cycle", int'(doutLog[a2]), 16'h2222);
    chk("R3 data same cycle", int'(doutLog[a3]), 16'h3333);
    chk("R3 oe", int'({oeLog[a], oeLog[a2], oeLog[a3]}), 7);
    chk("R3 dqm low", int'({dqmLog[a], dqmLog[a2], dqmLog[a3]}), 0);
    for (int i = 1; i < BL; i++) begin
      chk("R8 leftover masked", int'(dqmLog[a3+i]), 1);
      chk("R8 nop", int'(cmdLog[a3+i]), int'(NOP));
    end
    chk("R8 mask ends", int'(dqmLog[a3+BL]), 0);
    chk("R7 oe released", int'(oeLog[a3+1]), 0);

    // R6: write then read
    req(1'b1, 2'd0, 10'h100, 16'h4444, 1'b0, 3'd0, a);
    req(1'b0, 2'd1, 10'h104, 16'h0, 1'b0, 3'd0, a2);
    idle(10);
    chk("R6 read follows write", a2 - a, 1);
    chk("R6 read cmd", int'(cmdLog[a2]), int'(RD));
    chk("R6 dqm/oe low", int'({dqmLog[a2], oeLog[a2]}), 0);
    chk("R6 read word", int'(rdLog[a2+3]), int'(wordOf(2'd1, 10'h104, 0)));

    // R5: read interrupts read
    req(1'b0, 2'd0, 10'h008, 16'h0, 1'b0, 3'd0, a);
    req(1'b0, 2'd1, 10'h020, 16'h0, 1'b0, 3'd0, a2);
    idle(10);
    chk("R5 consecutive", a2 - a, 1);
    chk("R5 old word", int'(rdLog[a+3]), int'(wordOf(2'd0, 10'h008, 0)));
    for (int i = 0; i < BL; i++)
      chk("R5 new burst", int'(rdLog[a2+3+i]), int'(wordOf(2'd1, 10'h020, i)));
    chk("R5 valid run", int'({rvLog[a+3], rvLog[a2+3], rvLog[a2+6], rvLog[a2+7]}), 4'b1110);

    // R7: write waits for the read to drain
    req(1'b0, 2'd2, 10'h030, 16'h0, 1'b0, 3'd0, a);
    req(1'b1, 2'd2, 10'h030, 16'h5555, 1'b0, 3'd0, b);
    idle(8);
    chk("R7 write delay", b - a, CL + BL + 1);
    chk("R7 last word before", int'(rvLog[b-1]), 1);
    chk("R7 idle gap", int'(rvLog[b]), 0);
    chk("R7 write oe", int'(oeLog[b]), 1);

    // R9: truncated read by precharge
    req(1'b0, 2'd2, 10'h004, 16'h0, 1'b1, 3'd2, a);
    req(1'b0, 2'd0, 10'h000, 16'h0, 1'b0, 3'd0, b);
    idle(10);
    chk("R9 no A10", int'(addrLog[a][10]), 0);
    chk("R9 nop", int'(cmdLog[a+1]), int'(NOP));
    chk("R9 precharge", int'(cmdLog[a+2]), int'(PR));
    chk("R9 precharge bank", int'(bankLog[a+2]), 2);
    chk("R9 precharge A10", int'(addrLog[a+2][10]), 0);
    chk("R9 words", int'({rvLog[a+3], rvLog[a+4], rvLog[a+5]}), 3'b110);
    chk("R9 second word", int'(rdLog[a+4]), int'(wordOf(2'd2, 10'h004, 1)));
    chk("R9 next accept", b - a, 3);

    // R10: full read with auto precharge
    req(1'b0, 2'd3, 10'h00C, 16'h0, 1'b1, 3'd4, a);
    req(1'b0, 2'd1, 10'h000, 16'h0, 1'b0, 3'd0, b);
    idle(10);
    chk("R10 A10 set", int'(addrLog[a][10]), 1);
    chk("R10 hold", b - a, BL);
    for (int i = 1; i < BL; i++) chk("R10 nop", int'(cmdLog[a+i]), int'(NOP));
    for (int i = 0; i < BL; i++)
      chk("R10 words", int'(rdLog[a+3+i]), int'(wordOf(2'd3, 10'h00C, i)));

    // R11: write closed by precharge
    req(1'b1, 2'd1, 10'h050, 16'h6666, 1'b1, 3'd0, a);
    req(1'b1, 2'd0, 10'h051, 16'h7777, 1'b0, 3'd0, b);
    idle(8);
    chk("R11 A10 clear", int'(addrLog[a][10]), 0);
    chk("R11 mask", int'(dqmLog[a+1]), 1);
    chk("R11 precharge", int'(cmdLog[a+2]), int'(PR));
    chk("R11 precharge bank", int'(bankLog[a+2]), 1);
    chk("R11 next accept", b - a, 3);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
    $finish;
  end
endmodule